// File: doc/BRIEF.md
# Instruction Byte Stream Assembler

This block sits between an 8-bit program memory port and an instruction decoder. Program bytes arrive one at a time with a valid/ready handshake. The block gathers each opcode byte together with the operand bytes that belong to it, and presents the result as one instruction. The output carries the opcode, a 16-bit operand and the instruction length in bytes. An external decoder supplies a 2-bit addressing class alongside each opcode byte. The class sets how many operand bytes follow: none, one, or two. When there are two, the low byte comes first.

The block also keeps a program counter. The counter names the address of the next byte to fetch and moves forward by one for every byte the block takes. A synchronous load input can redirect it, for example on a jump. A finished instruction stays on the output until the consumer acknowledges it. While it waits, the block takes no new bytes.

The collector has four named states:
- COLLECT_OPCODE: waiting for an opcode.
- COLLECT_LOW: waiting for the first operand byte.
- COLLECT_HIGH: waiting for the second operand byte.
- PRESENT: holding a finished instruction.

The transitions are:
- COLLECT_OPCODE to PRESENT when the opcode is taken with no operand.
- COLLECT_OPCODE to COLLECT_LOW when the opcode is taken with one or two operand bytes.
- COLLECT_LOW to PRESENT when the single operand byte is taken.
- COLLECT_LOW to COLLECT_HIGH when the first of two operand bytes is taken.
- COLLECT_HIGH to PRESENT when the second operand byte is taken.
- PRESENT to COLLECT_OPCODE on acknowledge.
- Any state to COLLECT_OPCODE on synchronous reset.

Top module: `instr_byte_assembler`

## Requirements
- R1: After synchronous reset, the block takes the following actions:
  - `ins_valid` is 0.
  - `byte_ready` is 1.
  - `pc_out` equals `RESET_PC` (default 0).
  - The next byte taken is treated as an opcode.
- R2: Class 0 (no operand) gives a one-byte instruction. One cycle after the opcode is taken, `ins_valid` is 1, `ins_length` is 1 and `ins_operand` is 0.
- R3: Class 3 is reserved and behaves exactly like class 0: length 1 and operand 0.
- R4: Class 1 (8-bit operand) gives a two-byte instruction. `ins_operand[7:0]` is the byte after the opcode, `ins_operand[15:8]` is 0 and `ins_length` is 2.
- R5: Class 2 (16-bit operand) gives a three-byte instruction. The first operand byte goes to `ins_operand[7:0]`, the second to `ins_operand[15:8]`, and `ins_length` is 3.
- R6: While `ins_valid` is 1, the following hold:
  - `byte_ready` is 0.
  - Offered bytes are not taken.
  - The opcode, operand and length stay stable until the cycle in which `ins_ack` is 1.
  - One cycle after that cycle, `ins_valid` is 0 and `byte_ready` is 1.
- R7: `pc_out` increases by exactly one in the cycle after each byte is taken (`byte_valid` and `byte_ready` both 1), and is unchanged otherwise.
- R8: When `pc_load` is 1, `pc_out` equals `pc_load_value` one cycle later. This holds even if a byte is taken in the same cycle; that byte is still collected.
- R9: `byte_class` is sampled only with the opcode byte. Its value on operand bytes has no effect on length or operand.
- R10: A synchronous reset in the middle of an instruction discards the bytes collected so far. The next byte taken starts a new instruction as its opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | A program byte is offered |
| byte_data | input | 8 | Offered program byte |
| byte_class | input | 2 | Addressing class for an offered opcode byte (0 none, 1 byte, 2 word, 3 reserved) |
| byte_ready | output | 1 | Block can take a byte this cycle |
| pc_load | input | 1 | Redirect the program counter |
| pc_load_value | input | 16 | New program counter value |
| pc_out | output | 16 | Address of the next byte to fetch |
| ins_valid | output | 1 | A complete instruction is presented |
| ins_ack | input | 1 | Consumer takes the presented instruction |
| ins_opcode | output | 8 | Opcode byte |
| ins_operand | output | 16 | Assembled operand, low byte first in the stream |
| ins_length | output | 2 | Instruction length in bytes (1 to 3) |

## Verification
The bench sends random operand bytes with random class values, so a collector that re-reads the class on operand bytes ends instructions early or late. Class 1 follows class 2 instructions with leftover high bytes; a design that fails to clear the high byte shows a stale upper half. Bytes are offered during the hold window, so a design that accepts them there drops or corrupts stream bytes and miscounts the program counter. Directed cases cover a load that coincides with an accepted byte (a wrong priority leaves the counter one off) and a reset after two bytes of a three-byte instruction (a design that keeps the partial state would emit a bogus three-byte instruction).

// File: rtl/ibsa_pkg.sv
package ibsa_pkg;

    typedef enum logic [1:0] {
        COLLECT_OPCODE = 2'd0,
        COLLECT_LOW    = 2'd1,
        COLLECT_HIGH   = 2'd2,
        PRESENT        = 2'd3
    } collect_state_e;

    typedef enum logic [1:0] {
        CLASS_NONE  = 2'd0,
        CLASS_BYTE  = 2'd1,
        CLASS_WORD  = 2'd2,
        CLASS_SPARE = 2'd3
    } mode_class_e;

    localparam int unsigned CLASS_W   = 2;
    localparam int unsigned LEN_W     = 2;
    localparam int unsigned MAX_LANES = 2;

endpackage

// File: rtl/ibsa_class_decode.sv
module ibsa_class_decode
    import ibsa_pkg::*;
(
    input  logic [CLASS_W-1:0] mode_class,
    output logic [1:0]         operand_bytes,
    output logic [LEN_W-1:0]   total_length
);

    always_comb begin
        unique case (mode_class_e'(mode_class))
            CLASS_BYTE: begin
                operand_bytes = 2'd1;
                total_length  = 2'd2;
            end
            CLASS_WORD: begin
                operand_bytes = 2'd2;
                total_length  = 2'd3;
            end
            CLASS_NONE, CLASS_SPARE: begin
                operand_bytes = 2'd0;
                total_length  = 2'd1;
            end
            default: begin
                operand_bytes = 2'd0;
                total_length  = 2'd1;
            end
        endcase
    end

endmodule

// File: rtl/ibsa_collect_fsm.sv
module ibsa_collect_fsm
    import ibsa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_valid,
    input  logic                 ins_ack,
    input  logic [1:0]           operand_bytes,
    input  logic [LEN_W-1:0]     total_length,
    output logic                 byte_ready,
    output logic                 byte_taken,
    output logic                 opcode_we,
    output logic [MAX_LANES-1:0] lane_we,
    output logic                 present,
    output logic [LEN_W-1:0]     length_q
);

    collect_state_e state_q, state_d;
    logic           two_lanes_q;

    // state register and the per-instruction attributes latched with the opcode
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= COLLECT_OPCODE;
            two_lanes_q <= 1'b0;
            length_q    <= 2'd1;
        end else begin
            state_q <= state_d;
            if (opcode_we) begin
                two_lanes_q <= (operand_bytes == 2'd2);
                length_q    <= total_length;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            COLLECT_OPCODE:
                if (byte_valid) state_d = (operand_bytes == 2'd0) ? PRESENT : COLLECT_LOW;
            COLLECT_LOW:
                if (byte_valid) state_d = two_lanes_q ? COLLECT_HIGH : PRESENT;
            COLLECT_HIGH:
                if (byte_valid) state_d = PRESENT;
            PRESENT:
                if (ins_ack) state_d = COLLECT_OPCODE;
            default:
                state_d = COLLECT_OPCODE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        byte_ready = 1'b0;
        opcode_we  = 1'b0;
        lane_we    = '0;
        present    = 1'b0;
        unique case (state_q)
            COLLECT_OPCODE: begin
                byte_ready = 1'b1;
                opcode_we  = byte_valid;
            end
            COLLECT_LOW: begin
                byte_ready = 1'b1;
                lane_we[0] = byte_valid;
            end
            COLLECT_HIGH: begin
                byte_ready = 1'b1;
                lane_we[1] = byte_valid;
            end
            PRESENT: begin
                present = 1'b1;
            end
            default: begin
                byte_ready = 1'b0;
            end
        endcase
        byte_taken = byte_valid & byte_ready;
    end

endmodule

// File: rtl/ibsa_operand_lanes.sv
module ibsa_operand_lanes
    import ibsa_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic [MAX_LANES-1:0]        lane_we,
    input  logic [DATA_W-1:0]           data_in,
    output logic [MAX_LANES*DATA_W-1:0] operand
);

    // lane 0 holds the first operand byte of the stream, lane 1 the second
    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        logic [DATA_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || clear)    lane_q <= '0;
            else if (lane_we[g]) lane_q <= data_in;
        end
        assign operand[g*DATA_W +: DATA_W] = lane_q;
    end

endmodule

// File: rtl/ibsa_fetch_counter.sv
module ibsa_fetch_counter #(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_value,
    input  logic              step,
    output logic [ADDR_W-1:0] count
);

    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       count <= RESET_PC;
        else if (load) count <= load_value;
        else if (step) count <= count + STEP_ONE;
    end

endmodule

// File: rtl/instr_byte_assembler.sv
module instr_byte_assembler
    import ibsa_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        byte_valid,
    input  logic [DATA_W-1:0]           byte_data,
    input  logic [CLASS_W-1:0]          byte_class,
    output logic                        byte_ready,
    input  logic                        pc_load,
    input  logic [ADDR_W-1:0]           pc_load_value,
    output logic [ADDR_W-1:0]           pc_out,
    output logic                        ins_valid,
    input  logic                        ins_ack,
    output logic [DATA_W-1:0]           ins_opcode,
    output logic [MAX_LANES*DATA_W-1:0] ins_operand,
    output logic [LEN_W-1:0]            ins_length
);

    logic [1:0]           operand_bytes;
    logic [LEN_W-1:0]     total_length;
    logic                 byte_taken;
    logic                 opcode_we;
    logic [MAX_LANES-1:0] lane_we;
    logic [DATA_W-1:0]    opcode_q;

    ibsa_class_decode u_decode (
        .mode_class    (byte_class),
        .operand_bytes (operand_bytes),
        .total_length  (total_length)
    );

    ibsa_collect_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .byte_valid    (byte_valid),
        .ins_ack       (ins_ack),
        .operand_bytes (operand_bytes),
        .total_length  (total_length),
        .byte_ready    (byte_ready),
        .byte_taken    (byte_taken),
        .opcode_we     (opcode_we),
        .lane_we       (lane_we),
        .present       (ins_valid),
        .length_q      (ins_length)
    );

    ibsa_operand_lanes #(.DATA_W(DATA_W)) u_lanes (
        .clk     (clk),
        .rst     (rst),
        .clear   (opcode_we),
        .lane_we (lane_we),
        .data_in (byte_data),
        .operand (ins_operand)
    );

    ibsa_fetch_counter #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .load       (pc_load),
        .load_value (pc_load_value),
        .step       (byte_taken),
        .count      (pc_out)
    );

    always_ff @(posedge clk) begin
        if (rst)            opcode_q <= '0;
        else if (opcode_we) opcode_q <= byte_data;
    end

    assign ins_opcode = opcode_q;

endmodule

// File: rtl/ibsa_checker.sv
module ibsa_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                byte_valid,
    input logic                byte_ready,
    input logic                pc_load,
    input logic [ADDR_W-1:0]   pc_load_value,
    input logic [ADDR_W-1:0]   pc_out,
    input logic                ins_valid,
    input logic                ins_ack,
    input logic [DATA_W-1:0]   ins_opcode,
    input logic [2*DATA_W-1:0] ins_operand,
    input logic [1:0]          ins_length
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!ins_valid && byte_ready));

    a_r2_single_byte_no_operand: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_length == 2'd1) |-> (ins_operand == '0));

    a_r4_byte_operand_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_length == 2'd2) |-> (ins_operand[2*DATA_W-1:DATA_W] == '0));

    a_r5_length_in_range: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> (ins_length != 2'd0));

    a_r6_no_take_while_present: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> !byte_ready);

    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ack) |=> (ins_valid && $stable(ins_opcode)
                                     && $stable(ins_operand) && $stable(ins_length)));

    a_r6_release_on_ack: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_ack) |=> (!ins_valid && byte_ready));

    a_r7_pc_steps: assert property (@(posedge clk) disable iff (rst)
        (!pc_load && byte_valid && byte_ready) |=> (pc_out == $past(pc_out) + ADDR_W'(1)));

    a_r7_pc_holds: assert property (@(posedge clk) disable iff (rst)
        (!pc_load && !(byte_valid && byte_ready)) |=> $stable(pc_out));

    a_r8_pc_load: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (pc_out == $past(pc_load_value)));

endmodule

bind instr_byte_assembler ibsa_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .byte_valid    (byte_valid),
    .byte_ready    (byte_ready),
    .pc_load       (pc_load),
    .pc_load_value (pc_load_value),
    .pc_out        (pc_out),
    .ins_valid     (ins_valid),
    .ins_ack       (ins_ack),
    .ins_opcode    (ins_opcode),
    .ins_operand   (ins_operand),
    .ins_length    (ins_length)
);

// File: tb/sim_instr_byte_assembler.sv
module sim_instr_byte_assembler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [1:0]  byte_class = '0;
    logic        byte_ready;
    logic        pc_load = 1'b0;
    logic [15:0] pc_load_value = '0;
    logic [15:0] pc_out;
    logic        ins_valid;
    logic        ins_ack = 1'b0;
    logic [7:0]  ins_opcode;
    logic [15:0] ins_operand;
    logic [1:0]  ins_length;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] model_pc = 16'h0000;

    always #10 clk = ~clk;

    instr_byte_assembler u0 (
        .clk           (clk),
        .rst           (rst),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .byte_class    (byte_class),
        .byte_ready    (byte_ready),
        .pc_load       (pc_load),
        .pc_load_value (pc_load_value),
        .pc_out        (pc_out),
        .ins_valid     (ins_valid),
        .ins_ack       (ins_ack),
        .ins_opcode    (ins_opcode),
        .ins_operand   (ins_operand),
        .ins_length    (ins_length)
    );

    function automatic logic [1:0] exp_len(input logic [1:0] cls);
        return (cls == 2'd1) ? 2'd2 : (cls == 2'd2) ? 2'd3 : 2'd1;
    endfunction

    function automatic logic [15:0] exp_operand(input logic [1:0] cls,
                                                input logic [7:0] lo, input logic [7:0] hi);
        return (cls == 2'd1) ? {8'h00, lo} : (cls == 2'd2) ? {hi, lo} : 16'h0000;
    endfunction

    function automatic string class_tag(input logic [1:0] cls);
        return (cls == 2'd1) ? "R4" : (cls == 2'd2) ? "R5" : (cls == 2'd3) ? "R3" : "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all drive tasks start and end just after a falling edge
    task automatic send_byte(input logic [7:0] d, input logic [1:0] c);
        check("R6 ready before byte", 32'(byte_ready), 32'd1);
        byte_valid = 1'b1;
        byte_data  = d;
        byte_class = c;
        @(negedge clk);
        byte_valid = 1'b0;
        model_pc   = model_pc + 16'd1;
        check("R7 pc after byte", 32'(pc_out), 32'(model_pc));
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R7 pc idle", 32'(pc_out), 32'(model_pc));
            check("R6 no early valid", 32'(ins_valid), 32'd0);
        end
    endtask

    task automatic expect_instr(input logic [1:0] cls, input logic [7:0] op,
                                input logic [7:0] lo, input logic [7:0] hi, input int hold);
        string t = class_tag(cls);
        check({t, " valid"}, 32'(ins_valid), 32'd1);
        check({t, " opcode"}, 32'(ins_opcode), 32'(op));
        check({t, " operand"}, 32'(ins_operand), 32'(exp_operand(cls, lo, hi)));
        check({t, " length"}, 32'(ins_length), 32'(exp_len(cls)));
        for (int i = 0; i < hold; i++) begin
            byte_valid = 1'b1;
            byte_data  = 8'($urandom);
            byte_class = 2'($urandom);
            @(negedge clk);
            check("R6 ready low while held", 32'(byte_ready), 32'd0);
            check("R6 operand stable", 32'(ins_operand), 32'(exp_operand(cls, lo, hi)));
            check("R6 pc unchanged while held", 32'(pc_out), 32'(model_pc));
        end
        byte_valid = 1'b0;
        ins_ack = 1'b1;
        @(negedge clk);
        ins_ack = 1'b0;
        check("R6 valid drops after ack", 32'(ins_valid), 32'd0);
        check("R6 ready after ack", 32'(byte_ready), 32'd1);
    endtask

    // operand bytes carry a random class to exercise R9
    task automatic run_instr(input logic [1:0] cls, input logic [7:0] op,
                             input logic [7:0] lo, input logic [7:0] hi);
        send_byte(op, cls);
        if (cls == 2'd1 || cls == 2'd2) begin
            check("R9 waits for operand", 32'(ins_valid), 32'd0);
            gap($urandom_range(0, 2));
            send_byte(lo, 2'($urandom));
        end
        if (cls == 2'd2) begin
            check("R9 waits for high byte", 32'(ins_valid), 32'd0);
            gap($urandom_range(0, 2));
            send_byte(hi, 2'($urandom));
        end
        expect_instr(cls, op, lo, hi, $urandom_range(0, 3));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 valid after reset", 32'(ins_valid), 32'd0);
        check("R1 ready after reset", 32'(byte_ready), 32'd1);
        check("R1 pc after reset", 32'(pc_out), 32'h0000);

        // directed: each class, and R9 with a misleading class on operand bytes
        run_instr(2'd0, 8'hEA, 8'h00, 8'h00);
        run_instr(2'd3, 8'h02, 8'h00, 8'h00);
        run_instr(2'd2, 8'hAD, 8'h34, 8'h12);
        run_instr(2'd1, 8'hA9, 8'h7F, 8'h00);
        send_byte(8'h4C, 2'd2);
        send_byte(8'hCD, 2'd0);
        check("R9 class ignored on operand", 32'(ins_valid), 32'd0);
        send_byte(8'hAB, 2'd1);
        expect_instr(2'd2, 8'h4C, 8'hCD, 8'hAB, 1);

        // R8: load with no byte, then load coinciding with a taken byte
        pc_load = 1'b1;
        pc_load_value = 16'h8000;
        @(negedge clk);
        pc_load = 1'b0;
        model_pc = 16'h8000;
        check("R8 pc load", 32'(pc_out), 32'h8000);
        pc_load = 1'b1;
        pc_load_value = 16'hBEEF;
        byte_valid = 1'b1;
        byte_data = 8'h60;
        byte_class = 2'd0;
        @(negedge clk);
        pc_load = 1'b0;
        byte_valid = 1'b0;
        model_pc = 16'hBEEF;
        check("R8 load wins over step", 32'(pc_out), 32'hBEEF);
        expect_instr(2'd0, 8'h60, 8'h00, 8'h00, 0);

        // R10: reset after two bytes of a three-byte instruction
        send_byte(8'h8D, 2'd2);
        send_byte(8'h11, 2'd2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_pc = 16'h0000;
        check("R10 valid after mid reset", 32'(ins_valid), 32'd0);
        check("R10 pc after mid reset", 32'(pc_out), 32'h0000);
        send_byte(8'hE8, 2'd0);
        check("R10 new opcode after reset", 32'(ins_length), 32'd1);
        expect_instr(2'd0, 8'hE8, 8'h00, 8'h00, 0);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [1:0] c = 2'($urandom);
            run_instr(c, 8'($urandom), 8'($urandom), 8'($urandom));
            gap($urandom_range(0, 1));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule